// File: doc/BRIEF.md
# Descriptor Ring Pointer Bank

This block holds the programming state of a small set of DMA descriptor rings and keeps each ring's producer and consumer pointers. Software owns the head pointer and moves it forward as it posts descriptors. The device side owns the tail pointer and moves it forward one slot for each descriptor it retires. Each retired descriptor also adds one credit, and software hands credits back by writing the number it has taken.

The host sees a flat 32-bit register window. The port carries word addresses, so a byte offset is divided by four. Every ring has an eight-word group. The host can set a 64-bit base address, choose a power-of-two ring size at run time, and reset a ring's pointers without losing its base or size. Empty and full flags for each ring, plus two sticky error flags for each ring, leave the block as ports.

Top module: `dring_ptr_bank`

## Requirements
- R1: The group for ring r starts at word address 0x400 + 8*r, which is byte 0x1000 + 32*r. The word offsets inside a group are: 0 base low, 1 base high, 2 size, 3 head, 4 tail, 5 control, 6 credits, 7 reserved. The reserved word, any address outside the ring groups, and any group of a ring index at or above NUM_RINGS read as zero, and writes to them change nothing.
- R2: A write to base low is only held pending and leaves the readable base unchanged. A write to base high commits both halves at once. Bits 2:0 of the base always read zero.
- R3: A size write is accepted only if the value is a power of two from 2 to 65536. An accepted write stores the size and clears head, tail and credits. Any other value leaves the ring unchanged and sets the sticky flag err_size[r].
- R4: ring_empty[r] is high when head equals tail. ring_full[r] is high when (head+1) mod size equals tail.
- R5: A head write is accepted only if the value is below the size and moving head forward to it, modulo size, passes no more slots than are free (at most size-1 slots in use afterwards). Otherwise head is unchanged and the sticky flag err_head[r] is set.
- R6: While dev_take[r] is high, a ring that is not empty advances its tail by one modulo size each cycle. dev_take[r] has no effect on an empty ring. Host writes to the tail word are ignored.
- R7: Each accepted take adds one to credits. A credits write subtracts the written value from the count, after the same-cycle take has been added, and the result floors at zero.
- R8: Writing control with bit 0 set clears head, tail and credits on the next edge and keeps base and size. A control write with bit 0 clear has no effect. Control always reads zero.
- R9: After reset, every ring has size 2, with base, head, tail and credits at zero, and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_wr | input | 1 | Host write strobe |
| hs_waddr | input | 14 | Host word address |
| hs_wdata | input | 32 | Host write data |
| hs_rdata | output | 32 | Read data for hs_waddr, combinational |
| dev_take | input | NUM_RINGS | Device retires one descriptor per ring |
| ring_empty | output | NUM_RINGS | Ring empty flags |
| ring_full | output | NUM_RINGS | Ring full flags |
| err_size | output | NUM_RINGS | Sticky flag for a rejected size write |
| err_head | output | NUM_RINGS | Sticky flag for a rejected head write |

## Verification
An eight-entry ring is driven through a chosen sequence. Head jumps to exactly full, a write one slot past full is rejected, a write beyond the size is rejected, and tail retires across the wrap point. Together these separate a correct modulo comparison from one that ignores wrap or lets the ring overrun. Size writes of invalid values are mixed with the maximum legal size, and a take is issued in the same cycle as a credits write, which exposes ordering mistakes in the credit arithmetic. A random phase then interleaves writes to every word, ring resets, size changes and takes on two rings. A behavioural model checks every output and the current read word on each clock during this phase.

// File: rtl/dring_ptr_bank.sv
module dring_ptr_bank #(
  parameter int NUM_RINGS  = 4,
  parameter int PTR_W      = 16,
  parameter int RESET_SIZE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hs_wr,
  input  logic [13:0]          hs_waddr,
  input  logic [31:0]          hs_wdata,
  output logic [31:0]          hs_rdata,
  input  logic [NUM_RINGS-1:0] dev_take,
  output logic [NUM_RINGS-1:0] ring_empty,
  output logic [NUM_RINGS-1:0] ring_full,
  output logic [NUM_RINGS-1:0] err_size,
  output logic [NUM_RINGS-1:0] err_head
);
  localparam int SZ_W = PTR_W + 1;
  localparam logic [SZ_W-1:0] RST_SZ = SZ_W'(RESET_SIZE);
  localparam logic [3:0] GRP_PAGE = 4'h1;
  localparam logic [2:0] W_BLO = 3'd0, W_BHI = 3'd1, W_SIZE = 3'd2, W_HEAD = 3'd3,
                         W_TAIL = 3'd4, W_CTRL = 3'd5, W_CRED = 3'd6;

  wire       grp = hs_waddr[13:10] == GRP_PAGE;
  wire [6:0] idx = hs_waddr[9:3];
  wire [2:0] off = hs_waddr[2:0];

  wire size_ok = (hs_wdata[31:SZ_W] == '0) && ($countones(hs_wdata) == 1) && !hs_wdata[0];

  logic [NUM_RINGS-1:0][31:0] rd_w;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    logic [63:3]      base_q;
    logic [31:3]      stage_q;
    logic [SZ_W-1:0]  size_q;
    logic [PTR_W-1:0] head_q, tail_q;
    logic [31:0]      cred_q;
    logic             es_q, eh_q;

    wire sel = hs_wr & grp & (idx == 7'(r));
    wire [PTR_W-1:0] pmask = PTR_W'(size_q - SZ_W'(1));
    wire [PTR_W-1:0] hw    = hs_wdata[PTR_W-1:0];
    wire             h_fit = (hs_wdata[31:PTR_W] == '0) && ((hw & ~pmask) == '0);
    wire [PTR_W-1:0] adv   = (hw - head_q) & pmask;
    wire [PTR_W-1:0] free  = (tail_q - head_q - PTR_W'(1)) & pmask;
    wire             h_ok  = h_fit && (adv <= free);
    wire             empty = head_q == tail_q;
    wire             take  = dev_take[r] & ~empty;
    wire [PTR_W-1:0] tail_nx = (tail_q + PTR_W'(1)) & pmask;
    wire [32:0]      csum  = {1'b0, cred_q} + 33'(take);
    wire             csub  = sel && off == W_CRED;
    wire [31:0]      cred_nx = !csub ? csum[31:0] :
                               (csum > {1'b0, hs_wdata}) ? 32'(csum - {1'b0, hs_wdata}) : 32'd0;
    wire             clr   = sel && ((off == W_CTRL && hs_wdata[0]) || (off == W_SIZE && size_ok));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        stage_q <= '0;
        size_q  <= RST_SZ;
        head_q  <= '0;
        tail_q  <= '0;
        cred_q  <= '0;
        es_q    <= 1'b0;
        eh_q    <= 1'b0;
      end else begin
        if (clr) begin
          head_q <= '0;
          tail_q <= '0;
          cred_q <= '0;
        end else begin
          if (take) tail_q <= tail_nx;
          cred_q <= cred_nx;
          if (sel && off == W_HEAD && h_ok) head_q <= hw;
        end
        if (sel && off == W_SIZE) begin
          if (size_ok) size_q <= hs_wdata[SZ_W-1:0];
          else es_q <= 1'b1;
        end
        if (sel && off == W_HEAD && !h_ok) eh_q <= 1'b1;
        if (sel && off == W_BLO) stage_q <= hs_wdata[31:3];
        if (sel && off == W_BHI) base_q <= {hs_wdata, stage_q};
      end
    end

    assign ring_empty[r] = empty;
    assign ring_full[r]  = ((head_q + PTR_W'(1)) & pmask) == tail_q;
    assign err_size[r]   = es_q;
    assign err_head[r]   = eh_q;

    assign rd_w[r] = (off == W_BLO)  ? {base_q[31:3], 3'b000} :
                     (off == W_BHI)  ? base_q[63:32] :
                     (off == W_SIZE) ? {{(32-SZ_W){1'b0}}, size_q} :
                     (off == W_HEAD) ? {{(32-PTR_W){1'b0}}, head_q} :
                     (off == W_TAIL) ? {{(32-PTR_W){1'b0}}, tail_q} :
                     (off == W_CRED) ? cred_q : 32'd0;
  end

  always_comb begin
    hs_rdata = '0;
    for (int r = 0; r < NUM_RINGS; r++)
      if (grp && idx == 7'(r)) hs_rdata = rd_w[r];
  end
endmodule

module dring_ptr_chk #(
  parameter int NUM_RINGS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hs_wr,
  input logic [13:0]          hs_waddr,
  input logic [31:0]          hs_rdata,
  input logic [NUM_RINGS-1:0] ring_empty,
  input logic [NUM_RINGS-1:0] ring_full,
  input logic [NUM_RINGS-1:0] err_size,
  input logic [NUM_RINGS-1:0] err_head
);
  a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_empty & ring_full) == '0);

  a_r4_full_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_wr |=> ((ring_full & ~$past(ring_full)) == '0));

  a_r6_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_wr |=> ((ring_empty & $past(ring_empty)) == $past(ring_empty)));

  a_r3_size_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_size & $past(err_size)) == $past(err_size)));

  a_r5_head_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_head & $past(err_head)) == $past(err_head)));

  a_r5_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (err_head != $past(err_head)) |-> $past(hs_wr));

  a_r8_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_waddr[13:10] == 4'h1 && (hs_waddr[2:0] == 3'd5 || hs_waddr[2:0] == 3'd7)) |-> hs_rdata == 32'd0);
endmodule

bind dring_ptr_bank dring_ptr_chk #(.NUM_RINGS(NUM_RINGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_wr(hs_wr), .hs_waddr(hs_waddr), .hs_rdata(hs_rdata),
  .ring_empty(ring_empty), .ring_full(ring_full), .err_size(err_size), .err_head(err_head)
);

// File: tb/tb_dring_ptr_bank.sv
module tb_dring_ptr_bank;
  localparam int CLK_P = 10;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hs_wr = 1'b0;
  logic [13:0]   hs_waddr = '0;
  logic [31:0]   hs_wdata = '0;
  logic [31:0]   hs_rdata;
  logic [NR-1:0] dev_take = '0;
  logic [NR-1:0] ring_empty, ring_full, err_size, err_head;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dring_ptr_bank #(.NUM_RINGS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .hs_wr(hs_wr), .hs_waddr(hs_waddr), .hs_wdata(hs_wdata),
    .hs_rdata(hs_rdata), .dev_take(dev_take), .ring_empty(ring_empty), .ring_full(ring_full),
    .err_size(err_size), .err_head(err_head)
  );

  longint m_base[NR], m_stage[NR], m_size[NR], m_head[NR], m_tail[NR], m_cred[NR];
  bit     m_es[NR], m_eh[NR];

  function automatic bit size_legal(longint w);
    return w >= 2 && w <= 65536 && (w & (w - 1)) == 0;
  endfunction

  function automatic string off_tag(logic [13:0] a);
    if (a[13:10] != 4'h1 || a[9:3] >= NR) return "R1";
    case (a[2:0])
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3:       return "R5";
      3'd4:       return "R6";
      3'd5:       return "R8";
      3'd6:       return "R7";
      default:    return "R1";
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [13:0] a);
    int r;
    if (a[13:10] != 4'h1 || a[9:3] >= NR) return 32'd0;
    r = int'(a[9:3]);
    case (a[2:0])
      3'd0: return 32'(m_base[r]);
      3'd1: return 32'(m_base[r] >> 32);
      3'd2: return 32'(m_size[r]);
      3'd3: return 32'(m_head[r]);
      3'd4: return 32'(m_tail[r]);
      3'd6: return 32'(m_cred[r]);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int r = 0; r < NR; r++) begin
      bit sel, take, cleared;
      int off;
      longint w, c;
      if (!rst_n) begin
        m_base[r] = 0; m_stage[r] = 0; m_size[r] = 2; m_head[r] = 0;
        m_tail[r] = 0; m_cred[r] = 0; m_es[r] = 0; m_eh[r] = 0;
      end else begin
        sel = hs_wr && hs_waddr[13:10] == 4'h1 && int'(hs_waddr[9:3]) == r;
        off = int'(hs_waddr[2:0]);
        w = longint'(hs_wdata);
        take = dev_take[r] && m_head[r] != m_tail[r];
        cleared = 0;
        if (sel && off == 5 && w[0]) cleared = 1;
        if (sel && off == 2) begin
          if (size_legal(w)) begin m_size[r] = w; cleared = 1; end
          else m_es[r] = 1;
        end
        if (cleared) begin
          m_head[r] = 0; m_tail[r] = 0; m_cred[r] = 0;
        end else begin
          if (sel && off == 3) begin
            if (w < m_size[r] &&
                (w - m_head[r] + m_size[r]) % m_size[r] <=
                (m_tail[r] - m_head[r] - 1 + 2 * m_size[r]) % m_size[r])
              m_head[r] = w;
            else m_eh[r] = 1;
          end
          if (take) m_tail[r] = (m_tail[r] + 1) % m_size[r];
          c = m_cred[r] + (take ? 1 : 0);
          if (sel && off == 6) m_cred[r] = c > w ? c - w : 0;
          else m_cred[r] = c;
        end
        if (sel && off == 0) m_stage[r] = w & ~longint'(7);
        if (sel && off == 1) m_base[r] = (w << 32) | m_stage[r];
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int r = 0; r < NR; r++) begin
        chk("R4", "empty", 64'(ring_empty[r]), 64'(m_head[r] == m_tail[r]));
        chk("R4", "full", 64'(ring_full[r]), 64'((m_head[r] + 1) % m_size[r] == m_tail[r]));
        chk("R3", "err_size", 64'(err_size[r]), 64'(m_es[r]));
        chk("R5", "err_head", 64'(err_head[r]), 64'(m_eh[r]));
      end
      chk(off_tag(hs_waddr), "model read", 64'(hs_rdata), 64'(m_read(hs_waddr)));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int ra(int r, int boff);
    return 'h1000 + 32 * r + boff;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    hs_waddr = 14'(a >> 2);
    hs_wdata = d;
    hs_wr = 1'b1;
    step();
    hs_wr = 1'b0;
  endtask

  task automatic rdx(int a, logic [31:0] exp, string tag);
    hs_waddr = 14'(a >> 2);
    #1;
    chk(tag, "read", 64'(hs_rdata), 64'(exp));
  endtask

  task automatic take_n(int r, int n);
    for (int i = 0; i < n; i++) begin
      dev_take[r] = 1'b1;
      step();
    end
    dev_take[r] = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog R9: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    rdx(ra(0, 8), 2, "R9");
    rdx(ra(3, 12), 0, "R9");
    rdx(ra(2, 0), 0, "R9");
    chk("R9", "empty", 64'(ring_empty), 64'hF);
    chk("R9", "errors", 64'({err_size, err_head}), 64'h0);

    // R2 base staging
    wr(ra(1, 0), 32'h1234_5677);
    rdx(ra(1, 0), 0, "R2");
    wr(ra(1, 4), 32'hABCD_0001);
    rdx(ra(1, 0), 32'h1234_5670, "R2");
    rdx(ra(1, 4), 32'hABCD_0001, "R2");
    wr(ra(0, 0), 32'h0000_0108);
    wr(ra(0, 4), 32'h0000_0002);

    // R3 size
    wr(ra(0, 8), 3);
    chk("R3", "err_size after 3", 64'(err_size[0]), 1);
    rdx(ra(0, 8), 2, "R3");
    wr(ra(0, 8), 8);
    rdx(ra(0, 8), 8, "R3");
    wr(ra(2, 8), 32'h1_0000);
    rdx(ra(2, 8), 32'h1_0000, "R3");
    chk("R3", "err_size max legal", 64'(err_size[2]), 0);
    wr(ra(2, 8), 32'h2_0000);
    chk("R3", "err_size over max", 64'(err_size[2]), 1);
    rdx(ra(2, 8), 32'h1_0000, "R3");

    // R5 head and R6 tail on size 8
    wr(ra(0, 12), 5);
    rdx(ra(0, 12), 5, "R5");
    take_n(0, 3);
    rdx(ra(0, 16), 3, "R6");
    rdx(ra(0, 24), 3, "R7");
    wr(ra(0, 12), 2);
    rdx(ra(0, 12), 2, "R5");
    chk("R4", "full", 64'(ring_full[0]), 1);
    wr(ra(0, 12), 3);
    chk("R5", "err_head past tail", 64'(err_head[0]), 1);
    rdx(ra(0, 12), 2, "R5");
    wr(ra(0, 12), 9);
    rdx(ra(0, 12), 2, "R5");

    take_n(0, 7);
    rdx(ra(0, 16), 2, "R6");
    chk("R4", "empty after wrap", 64'(ring_empty[0]), 1);
    take_n(0, 2);
    rdx(ra(0, 16), 2, "R6");
    rdx(ra(0, 24), 10, "R6");
    wr(ra(0, 16), 5);
    rdx(ra(0, 16), 2, "R6");

    // R7 credits
    wr(ra(0, 24), 4);
    rdx(ra(0, 24), 6, "R7");
    wr(ra(0, 12), 4);
    dev_take[0] = 1'b1;
    wr(ra(0, 24), 1);
    dev_take[0] = 1'b0;
    rdx(ra(0, 24), 6, "R7");
    rdx(ra(0, 16), 3, "R7");
    wr(ra(0, 24), 100);
    rdx(ra(0, 24), 0, "R7");

    // R8 ring reset
    wr(ra(0, 20), 0);
    rdx(ra(0, 12), 4, "R8");
    wr(ra(0, 20), 1);
    rdx(ra(0, 12), 0, "R8");
    rdx(ra(0, 16), 0, "R8");
    rdx(ra(0, 8), 8, "R8");
    rdx(ra(0, 0), 32'h108, "R8");
    rdx(ra(0, 4), 2, "R8");
    rdx(ra(0, 20), 0, "R8");

    // R1 reserved and undecoded space
    wr(ra(0, 28), 32'hFFFF);
    rdx(ra(0, 28), 0, "R1");
    rdx('h0010, 0, "R1");
    wr(ra(4, 8), 4);
    rdx(ra(4, 8), 0, "R1");
    wr('h0008, 3);
    rdx(ra(0, 8), 8, "R1");
    chk("R1", "no alias error", 64'(err_size[0]), 1);
    chk("R1", "ring3 untouched", 64'(err_size[3]), 0);

    // random phase, compared every clock by the model
    wr(ra(3, 8), 4);
    for (int i = 0; i < 3000; i++) begin
      int r, o, pick;
      r = ($urandom_range(0, 1) == 0) ? 0 : 3;
      o = $urandom_range(0, 7);
      pick = $urandom_range(0, 9);
      hs_waddr = 14'(ra(r, 4 * o) >> 2);
      hs_wr = $urandom_range(0, 1) == 1;
      hs_wdata = (o == 2) ? ((pick < 6) ? (32'd1 << pick) : 32'(pick)) :
                 (o == 5) ? 32'($urandom_range(0, 1)) : 32'(pick);
      dev_take = NR'($urandom_range(0, (1 << NR) - 1));
      step();
    end
    hs_wr = 1'b0;
    dev_take = '0;
    step();
    summary();
    $finish;
  end
endmodule